// File: doc/BRIEF.md
# Auxiliary Frame-Word Insertion with Control-Byte Guard

The block sits between a user-side auxiliary write port and the word stream of a radio-interface framer. It runs a set of synchronization counters: a word index inside each basic frame, a basic-frame index inside the hyperframe, a hyperframe number and a basic-frame-group number. It also publishes a per-lane flag that tells the user which byte lanes of the current frame word are control bytes.

The user answers each counter position with a 32-bit data word and a 32-bit per-bit mask. These arrive a fixed number of clocks after the position was announced. That delay is set by a latency parameter. The block merges the masked data bits into the in-place frame word, which is modelled here as a plain input bus, and registers the result. Control bytes are protected: they always pass through unchanged. Any mask bit that reaches into a control byte raises a one-clock error pulse on the following clock. The rest of the word still merges normally.

Top module: `aux_insert_checker`

## Requirements
- R1: `ctrl_o` is 4'b1000 while `seq_o` is 0 and 4'b0000 otherwise. Bit 3 stands for byte lane 3, which is frame bits 31:24; bit i stands for bits 8i+7:8i.
- R2: `seq_o` advances by one on every clock out of reset and wraps from 3 to 0, giving four words per basic frame.
- R3: The counters chain on wrap. `bfi_o` advances when `seq_o` wraps and goes from BF_N-1 (default 255) to 0. `hfn_o` advances when `bfi_o` wraps and goes from HF_N-1 (default 149) to 0. `bfn_o` advances when `hfn_o` wraps and goes from RF_N-1 (default 4095) to 0.
- R4: The data and mask for the position named by the counters in clock t are taken from the inputs in clock t+LAT+1, where LAT is 0 to 3. The control flags applied to them are those that `ctrl_o` showed in clock t.
- R5: In non-control lanes, a mask bit of 1 takes the data bit and a mask bit of 0 keeps the frame bit. `merged_o` presents this result one clock after the data, mask and frame word were applied.
- R6: In lanes flagged as control for that position, `merged_o` equals the frame byte whatever the mask says.
- R7: `err_o` is high for exactly the one clock after a word whose mask has any bit set inside a control lane, and low otherwise. The non-control lanes of that word are still merged per R5.
- R8: A synchronous active-high reset clears all counters, the control-flag delay line, `merged_o` and `err_o`. The first LAT+1 words after reset see no control lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_word_i | input | 32 | In-place frame word, aligned with the data and mask |
| aux_data_i | input | 32 | Auxiliary data to insert |
| aux_mask_i | input | 32 | Per-bit insert mask, 1 = replace |
| seq_o | output | SEQ_W (2) | Word index inside the basic frame |
| bfi_o | output | BFI_W (8) | Basic-frame index inside the hyperframe |
| hfn_o | output | HFN_W (8) | Hyperframe number |
| bfn_o | output | BFN_W (12) | Basic-frame-group number |
| ctrl_o | output | 4 | Control-lane flags of the current position |
| merged_o | output | 32 | Registered merged frame word |
| err_o | output | 1 | One-clock pulse for a mask touching a control lane |

## Verification
The inputs go through phases. There are random masks and an all-ones mask, which tell a correct per-bit select from a word-level one and expose any write into a protected lane. An all-zero mask must reproduce the frame word exactly. A mask covering only the control lane must raise the error pulse yet leave the word equal to the frame. A mask covering only the other three lanes must merge without any error. Two instances differ in latency and counter limits: a latency off by one moves the expected error pulses and protected lanes to other words, and the small limits push every counter through its wrap inside the run. A reset in mid-run checks that the delay line is cleared together with the counters.

// File: rtl/aux_ins_pkg.sv
package aux_ins_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int LANE_W = WORD_W / LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    localparam lanes_t CTRL_FIRST = 4'b1000;

    typedef struct packed {
        word_t word;
        logic  err;
    } merge_out_t;

    function automatic word_t lane_bits(lanes_t flags);
        word_t w;
        for (int i = 0; i < LANES; i++) begin
            w[i*LANE_W +: LANE_W] = {LANE_W{flags[i]}};
        end
        return w;
    endfunction
endpackage

// File: rtl/aux_sync_counter.sv
module aux_sync_counter #(
    parameter int SEQ_N = 4,
    parameter int BF_N  = 256,
    parameter int HF_N  = 150,
    parameter int RF_N  = 4096,
    parameter int SEQ_W = 2,
    parameter int BFI_W = 8,
    parameter int HFN_W = 8,
    parameter int BFN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SEQ_W-1:0] seq_o,
    output logic [BFI_W-1:0] bfi_o,
    output logic [HFN_W-1:0] hfn_o,
    output logic [BFN_W-1:0] bfn_o
);
    logic seq_last, bfi_last, hfn_last, bfn_last;

    assign seq_last = (seq_o == SEQ_W'(SEQ_N - 1));
    assign bfi_last = (bfi_o == BFI_W'(BF_N - 1));
    assign hfn_last = (hfn_o == HFN_W'(HF_N - 1));
    assign bfn_last = (bfn_o == BFN_W'(RF_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_o <= '0;
            bfi_o <= '0;
            hfn_o <= '0;
            bfn_o <= '0;
        end else begin
            seq_o <= seq_last ? '0 : seq_o + 1'b1;
            if (seq_last) begin
                bfi_o <= bfi_last ? '0 : bfi_o + 1'b1;
                if (bfi_last) begin
                    hfn_o <= hfn_last ? '0 : hfn_o + 1'b1;
                    if (hfn_last) begin
                        bfn_o <= bfn_last ? '0 : bfn_o + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/aux_ctrl_pipe.sv
module aux_ctrl_pipe
    import aux_ins_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  lanes_t flags_i,
    output lanes_t flags_o
);
    lanes_t stage [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= flags_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign flags_o = stage[DEPTH-1];
endmodule

// File: rtl/aux_merge_unit.sv
module aux_merge_unit
    import aux_ins_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  word_t      frame_i,
    input  word_t      data_i,
    input  word_t      mask_i,
    input  lanes_t     ctrl_i,
    output merge_out_t out_o
);
    word_t      guard;
    word_t      eff_mask;
    merge_out_t next;

    always_comb begin
        guard     = lane_bits(ctrl_i);
        eff_mask  = mask_i & ~guard;
        next.word = (frame_i & ~eff_mask) | (data_i & eff_mask);
        next.err  = |(mask_i & guard);
    end

    always_ff @(posedge clk) begin
        if (rst) out_o <= '0;
        else     out_o <= next;
    end
endmodule

// File: rtl/aux_insert_checker.sv
module aux_insert_checker
    import aux_ins_pkg::*;
#(
    parameter int LAT   = 0,
    parameter int SEQ_N = 4,
    parameter int BF_N  = 256,
    parameter int HF_N  = 150,
    parameter int RF_N  = 4096,
    localparam int SEQ_W = $clog2(SEQ_N),
    localparam int BFI_W = $clog2(BF_N),
    localparam int HFN_W = $clog2(HF_N),
    localparam int BFN_W = $clog2(RF_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      frame_word_i,
    input  logic [31:0]      aux_data_i,
    input  logic [31:0]      aux_mask_i,
    output logic [SEQ_W-1:0] seq_o,
    output logic [BFI_W-1:0] bfi_o,
    output logic [HFN_W-1:0] hfn_o,
    output logic [BFN_W-1:0] bfn_o,
    output logic [3:0]       ctrl_o,
    output logic [31:0]      merged_o,
    output logic             err_o
);
    localparam int DEPTH = LAT + 1;

    lanes_t     ctrl_due;
    merge_out_t mres;

    aux_sync_counter #(
        .SEQ_N(SEQ_N), .BF_N(BF_N), .HF_N(HF_N), .RF_N(RF_N),
        .SEQ_W(SEQ_W), .BFI_W(BFI_W), .HFN_W(HFN_W), .BFN_W(BFN_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .seq_o (seq_o),
        .bfi_o (bfi_o),
        .hfn_o (hfn_o),
        .bfn_o (bfn_o)
    );

    assign ctrl_o = (seq_o == '0) ? CTRL_FIRST : '0;

    aux_ctrl_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .flags_i (ctrl_o),
        .flags_o (ctrl_due)
    );

    aux_merge_unit u_merge (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_word_i),
        .data_i  (aux_data_i),
        .mask_i  (aux_mask_i),
        .ctrl_i  (ctrl_due),
        .out_o   (mres)
    );

    assign merged_o = mres.word;
    assign err_o    = mres.err;
endmodule

// File: rtl/aux_insert_checker_sva.sv
module aux_insert_checker_sva
    import aux_ins_pkg::*;
#(
    parameter int LAT   = 0,
    parameter int SEQ_N = 4,
    parameter int BF_N  = 256,
    parameter int HF_N  = 150,
    parameter int SEQ_W = 2,
    parameter int BFI_W = 8,
    parameter int HFN_W = 8,
    parameter int BFN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [SEQ_W-1:0] seq,
    input logic [BFI_W-1:0] bfi,
    input logic [HFN_W-1:0] hfn,
    input logic [BFN_W-1:0] bfn,
    input logic [3:0]       ctrl,
    input logic [3:0]       ctrl_due,
    input logic [31:0]      frame,
    input logic [31:0]      mask,
    input logic [31:0]      merged,
    input logic             err
);
    logic seq_end, bfi_end, hfn_end, ctrl_hit;
    assign seq_end  = (seq == SEQ_W'(SEQ_N - 1));
    assign bfi_end  = (bfi == BFI_W'(BF_N - 1));
    assign hfn_end  = (hfn == HFN_W'(HF_N - 1));
    assign ctrl_hit = |(mask & lane_bits(ctrl_due));

    initial begin
        AST_LAT_RANGE: assert (LAT >= 0 && LAT <= 3); // R4
    end

    AST_CTRL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ctrl)); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst) !seq_end |=> seq == $past(seq) + 1'b1); // R2
    AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (rst) seq_end |=> seq == '0); // R2
    AST_BFI_HOLD: assert property (@(posedge clk) disable iff (rst) !seq_end |=> $stable(bfi) && $stable(hfn) && $stable(bfn)); // R3
    AST_BFI_WRAP: assert property (@(posedge clk) disable iff (rst) (seq_end && bfi_end) |=> bfi == '0); // R3
    AST_HFN_WRAP: assert property (@(posedge clk) disable iff (rst) (seq_end && bfi_end && hfn_end) |=> hfn == '0); // R3
    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst) ctrl_hit |=> err); // R7
    AST_ERR_CLR: assert property (@(posedge clk) disable iff (rst) !ctrl_hit |=> !err); // R7
    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> ((merged ^ $past(frame)) & $past(lane_bits(ctrl_due))) == '0); // R6
endmodule

bind aux_insert_checker aux_insert_checker_sva #(
    .LAT(LAT), .SEQ_N(SEQ_N), .BF_N(BF_N), .HF_N(HF_N),
    .SEQ_W(SEQ_W), .BFI_W(BFI_W), .HFN_W(HFN_W), .BFN_W(BFN_W)
) u_sva (
    .clk      (clk),
    .rst      (rst),
    .seq      (seq_o),
    .bfi      (bfi_o),
    .hfn      (hfn_o),
    .bfn      (bfn_o),
    .ctrl     (ctrl_o),
    .ctrl_due (ctrl_due),
    .frame    (frame_word_i),
    .mask     (aux_mask_i),
    .merged   (merged_o),
    .err      (err_o)
);

// File: tb/tb_aux_insert_checker.sv
`timescale 1ns/1ps
module tb_aux_insert_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] frame_w = '0, dat = '0, msk = '0;
    int          kc = 0;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) kc <= 0;
        else     kc <= kc + 1;
    end

    // instance with latency 2 and small counter limits
    logic [1:0]  a_seq; logic [2:0] a_bfi, a_hfn, a_bfn;
    logic [3:0]  a_ctrl; logic [31:0] a_mrg; logic a_err;
    aux_insert_checker #(.LAT(2), .SEQ_N(4), .BF_N(8), .HF_N(5), .RF_N(6)) dut (
        .clk(clk), .rst(rst), .frame_word_i(frame_w), .aux_data_i(dat), .aux_mask_i(msk),
        .seq_o(a_seq), .bfi_o(a_bfi), .hfn_o(a_hfn), .bfn_o(a_bfn),
        .ctrl_o(a_ctrl), .merged_o(a_mrg), .err_o(a_err));

    // instance with latency 0 and default limits
    logic [1:0]  b_seq; logic [7:0] b_bfi, b_hfn; logic [11:0] b_bfn;
    logic [3:0]  b_ctrl; logic [31:0] b_mrg; logic b_err;
    aux_insert_checker #(.LAT(0)) dut_l0 (
        .clk(clk), .rst(rst), .frame_word_i(frame_w), .aux_data_i(dat), .aux_mask_i(msk),
        .seq_o(b_seq), .bfi_o(b_bfi), .hfn_o(b_hfn), .bfn_o(b_bfn),
        .ctrl_o(b_ctrl), .merged_o(b_mrg), .err_o(b_err));

    task automatic chk(string what, string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, kc);
        end
    endtask

    task automatic check_inst(string nm, int lat, int bfn_lim, int hfn_lim, int rfn_lim,
                              int seq, int bfi, int hfn, int bfn,
                              logic [3:0] ctrl, logic [31:0] mrg, logic err);
        int s_e, b_e, h_e, f_e, pos;
        bit prot;
        logic [31:0] guard, eff, m_e;
        if (rst) begin
            chk({nm, " seq in reset"}, "R8", seq, 0);
            chk({nm, " bfi in reset"}, "R8", bfi, 0);
            chk({nm, " hfn in reset"}, "R8", hfn, 0);
            chk({nm, " bfn in reset"}, "R8", bfn, 0);
            chk({nm, " merged in reset"}, "R8", mrg, 0);
            chk({nm, " err in reset"}, "R8", err, 0);
            return;
        end
        s_e = kc % 4;
        b_e = (kc / 4) % bfn_lim;
        h_e = (kc / (4 * bfn_lim)) % hfn_lim;
        f_e = (kc / (4 * bfn_lim * hfn_lim)) % rfn_lim;
        chk({nm, " seq"}, "R2", seq, s_e);
        chk({nm, " bfi"}, "R3", bfi, b_e);
        chk({nm, " hfn"}, "R3", hfn, h_e);
        chk({nm, " bfn"}, "R3", bfn, f_e);
        chk({nm, " ctrl"}, "R1", ctrl, (s_e == 0) ? 4'b1000 : 4'b0000);
        // data applied in cycle kc-1 targets position of cycle kc-1-(lat+1)
        pos   = kc - 1 - (lat + 1);
        prot  = (pos >= 0) && (pos % 4 == 0);
        guard = prot ? 32'hFF00_0000 : 32'h0;
        eff   = msk & ~guard;
        m_e   = (frame_w & ~eff) | (dat & eff);
        if (pos < 0) chk({nm, " merged early"}, "R8", mrg, m_e);
        else if (prot) chk({nm, " merged protected"}, "R6", mrg, m_e);
        else chk({nm, " merged"}, "R5", mrg, m_e);
        chk({nm, " err timing"}, "R4/R7", err, (prot && (msk[31:24] != 8'h00)) ? 1 : 0);
    endtask

    task automatic drive();
        frame_w = $urandom;
        dat     = $urandom;
        if (kc < 200)       msk = $urandom;
        else if (kc < 400)  msk = 32'hFFFF_FFFF;
        else if (kc < 600)  msk = 32'h0;
        else if (kc < 800)  msk = 32'hFF00_0000;
        else if (kc < 1000) msk = 32'h00FF_FFFF;
        else                msk = $urandom & $urandom;
    endtask

    initial begin
        for (int c = 0; c < 2200; c++) begin
            @(negedge clk);
            check_inst("lat2", 2, 8, 5, 6, int'(a_seq), int'(a_bfi), int'(a_hfn), int'(a_bfn),
                       a_ctrl, a_mrg, a_err);
            check_inst("lat0", 0, 256, 150, 4096, int'(b_seq), int'(b_bfi), int'(b_hfn), int'(b_bfn),
                       b_ctrl, b_mrg, b_err);
            rst = (c < 4) || (c >= 1500 && c < 1503);
            drive();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule